// File: doc/BRIEF.md
# Signed-Digit Montgomery Modular Multiplier

This block computes a Montgomery product for an odd modulus M of N bits. The multiplier operand X is first rewritten as N+1 signed digits in which no two neighbouring digits are both nonzero. The block then works through those digits from the least significant end. On each step it adds nothing, the multiplicand Y, or the modular negative M−Y. It then adds a multiple of M, chosen so that the low bits cancel, and shifts the accumulator right. The accumulator is held as a pair of sum and carry words updated by two carry-save adders. A single carry-propagate addition and one compare-and-subtract produce the final reduced value.

A zero digit that follows the current digit is absorbed into the same step, which then divides by four instead of two. For this reason the number of steps, and hence the latency, depends on the value of X. The block is driven with a start pulse and parallel operands. It raises busy while it works and gives a one-cycle done pulse when the result port holds the new product. The result is X·Y·2^−(N+1) mod M, which the surrounding exponentiation logic is expected to account for.

Top module: `csd_mont_mul`

## Requirements
- R1: After reset, busy, done and result are all 0.
- R2: X is recoded into N+1 digits at positions 0..N. Each digit is −1, 0 or +1, no two adjacent digits are both nonzero, and the digits weighted by powers of two sum to X.
- R3: Each step consumes two digits when at least two remain and the next-higher digit is zero; otherwise it consumes one. With s steps, busy is high for exactly s+1 cycles after the accepting edge, and done is seen s+2 cycles after start is driven.
- R4: A zero digit adds nothing to the accumulator, a +1 digit adds Y, and a −1 digit adds M−Y.
- R5: Each step adds k·M, with k derived from the low two bits of the accumulator plus the digit term. After this addition the value is divisible by 2 for a single step and by 4 for a double step, so the shift is exact.
- R6: For M odd and X, Y < M, result equals X·Y·2^−(N+1) mod M and lies in [0, M).
- R7: The final value is formed by one carry-propagate addition of the sum word, the carry word and a pending carry bit. Before the conditional subtraction of M this value is below 2M.
- R8: done is high for exactly one cycle, with busy low in that cycle. result keeps its value until the next completion.
- R9: start is ignored while busy is high. The operation in flight and its operands are unaffected.
- R10: The boundary operands are handled: M = 1, zero operands, and X = Y = M−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_x | input | N | Multiplier X, below M |
| op_y | input | N | Multiplicand Y, below M |
| op_m | input | N | Odd modulus M |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | N | Reduced Montgomery product |

## Verification
The properties assume that M is odd and that X and Y are both below M. Under these conditions the carry-save words never overflow, the generator always finds a cancelling multiple of M, and a single subtraction is enough at the end. The stimulus only builds operand sets that meet these conditions: random moduli have bit 0 forced high and are kept at 3 or above, random operands are reduced modulo M, and the hand-picked boundary cases (M = 1, M = 3, all-ones moduli) are chosen to satisfy the same limits.

// File: rtl/csd_mont_pkg.sv
package csd_mont_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mm_state_t;

  // Multiple of the modulus that clears the low bits of t.
  // Single step: clear bit 0 (M odd, so k = t[0]).
  // Double step: clear bits 1:0; M is its own inverse modulo 4,
  // so k = -(t * M) mod 4.
  function automatic logic [1:0] corr_pick(input logic [1:0] t,
                                           input logic [1:0] m_lo,
                                           input logic       two_digits);
    logic [3:0] prod;
    logic [1:0] k;
    prod = {2'b00, t} * {2'b00, m_lo};
    if (two_digits) k = ~prod[1:0] + 2'd1;
    else            k = {1'b0, t[0]};
    return k;
  endfunction

endpackage

// File: rtl/csd_recoder.sv
module csd_recoder #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  output logic [N:0]   pos,
  output logic [N:0]   neg
);
  logic [N:0] xe, xh, x3, flip;

  // Non-adjacent form: x3 = x + x/2; positions where x3 and x/2 differ
  // carry a digit, whose sign comes from which of the two holds the 1.
  always_comb begin
    xe   = {1'b0, x};
    xh   = xe >> 1;
    x3   = xe + xh;
    flip = xh ^ x3;
    pos  = x3 & flip;
    neg  = xh & flip;
  end
endmodule

// File: rtl/csd_csa.sv
module csd_csa #(
  parameter int W = 19
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign s[i] = a[i] ^ b[i] ^ d[i];
    assign c[i] = (a[i] & b[i]) | (a[i] & d[i]) | (b[i] & d[i]);
  end
endmodule

// File: rtl/csd_step.sv
module csd_step
  import csd_mont_pkg::*;
#(
  parameter int W = 19
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  input  logic         e_in,
  input  logic [W-1:0] term,
  input  logic [W-1:0] m1,
  input  logic [W-1:0] m2,
  input  logic [W-1:0] m3,
  input  logic         pair,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out,
  output logic         e_out,
  output logic         red_s0,
  output logic         red_s1,
  output logic         red_c0
);
  logic [1:0]   t_lo, k;
  logic [W-1:0] corr, s1, c1, u1, s2, c2;

  // Low two bits of accumulator + digit term (exact: no higher-bit influence)
  assign t_lo = s_in[1:0] + c_in[1:0] + {1'b0, e_in} + term[1:0];
  assign k    = corr_pick(t_lo, m1[1:0], pair);

  always_comb begin
    case (k)
      2'd0:    corr = '0;
      2'd1:    corr = m1;
      2'd2:    corr = m2;
      default: corr = m3;
    endcase
  end

  csd_csa #(.W(W)) u_add_digit (.a(s_in), .b(c_in), .d(term), .s(s1), .c(c1));

  // Carry word moves up one place; the pending bit fills the vacant LSB.
  assign u1 = W'({c1, e_in});

  csd_csa #(.W(W)) u_add_mod (.a(s1), .b(u1), .d(corr), .s(s2), .c(c2));

  // value = s2 + 2*c2
  always_comb begin
    if (pair) begin
      s_out = s2 >> 2;
      c_out = c2 >> 1;
      e_out = c2[0];
    end else begin
      s_out = s2 >> 1;
      c_out = c2;
      e_out = 1'b0;
    end
  end

  assign red_s0 = s2[0];
  assign red_s1 = s2[1];
  assign red_c0 = c2[0];
endmodule

// File: rtl/csd_final.sv
module csd_final #(
  parameter int N = 16,
  parameter int W = N + 3
) (
  input  logic [W-1:0] s,
  input  logic [W-1:0] c,
  input  logic         e,
  input  logic [N-1:0] m,
  output logic [W-1:0] pre,
  output logic [N-1:0] res
);
  logic [W-1:0] mw;

  always_comb begin
    mw  = W'(m);
    pre = s + c + W'(e);
    if (pre >= mw) res = N'(pre - mw);
    else           res = N'(pre);
  end
endmodule

// File: rtl/csd_mont_mul.sv
module csd_mont_mul
  import csd_mont_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] op_x,
  input  logic [N-1:0] op_y,
  input  logic [N-1:0] op_m,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] result
);
  localparam int D  = N + 1;
  localparam int W  = N + 3;
  localparam int LW = $clog2(D + 1);

  mm_state_t    state;
  logic [N-1:0] y_q, ny_q, m_q, res_q;
  logic [W-1:0] m3_q, s_q, c_q;
  logic         e_q, done_q;
  logic [D-1:0] pos_q, neg_q;
  logic [LW-1:0] left_q;

  logic [D-1:0] rec_pos, rec_neg, nz_q;
  logic [W-1:0] term, m1_w, m2_w, nx_s, nx_c, pre_sum, in_m;
  logic         nx_e, pair, red_s0, red_s1, red_c0;
  logic [N-1:0] fin_res;

  csd_recoder #(.N(N)) u_rec (.x(op_x), .pos(rec_pos), .neg(rec_neg));

  // Digit selection: two digits when the next one is zero
  assign pair = (left_q >= LW'(2)) && !pos_q[1] && !neg_q[1];
  assign nz_q = pos_q | neg_q;

  // Partial-product select: 0, Y, or M-Y
  always_comb begin
    if (pos_q[0])      term = W'(y_q);
    else if (neg_q[0]) term = W'(ny_q);
    else               term = '0;
  end

  assign m1_w = W'(m_q);
  assign m2_w = {m1_w[W-2:0], 1'b0};
  assign in_m = W'(op_m);

  csd_step #(.W(W)) u_step (
    .s_in(s_q), .c_in(c_q), .e_in(e_q), .term(term),
    .m1(m1_w), .m2(m2_w), .m3(m3_q), .pair(pair),
    .s_out(nx_s), .c_out(nx_c), .e_out(nx_e),
    .red_s0(red_s0), .red_s1(red_s1), .red_c0(red_c0)
  );

  csd_final #(.N(N), .W(W)) u_fin (
    .s(s_q), .c(c_q), .e(e_q), .m(m_q), .pre(pre_sum), .res(fin_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      y_q    <= '0;
      ny_q   <= '0;
      m_q    <= '0;
      m3_q   <= '0;
      res_q  <= '0;
      s_q    <= '0;
      c_q    <= '0;
      e_q    <= 1'b0;
      pos_q  <= '0;
      neg_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          done_q <= 1'b0;
          if (start) begin
            y_q    <= op_y;
            ny_q   <= op_m - op_y;
            m_q    <= op_m;
            m3_q   <= in_m + {in_m[W-2:0], 1'b0};
            pos_q  <= rec_pos;
            neg_q  <= rec_neg;
            left_q <= LW'(D);
            s_q    <= '0;
            c_q    <= '0;
            e_q    <= 1'b0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          s_q <= nx_s;
          c_q <= nx_c;
          e_q <= nx_e;
          if (pair) begin
            pos_q  <= pos_q >> 2;
            neg_q  <= neg_q >> 2;
            left_q <= left_q - LW'(2);
            if (left_q == LW'(2)) state <= ST_FIN;
          end else begin
            pos_q  <= pos_q >> 1;
            neg_q  <= neg_q >> 1;
            left_q <= left_q - LW'(1);
            if (left_q == LW'(1)) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          res_q  <= fin_res;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

  // R2: recoded digits stay sparse and never both signs at one position
  assert_sparse_digits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (((nz_q & (nz_q >> 1)) == '0) && ((pos_q & neg_q) == '0)));

  // R5: the chosen modulus multiple makes the shifted-out bits zero
  assert_exact_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (!red_s0 && (!pair || (red_s1 == red_c0))));

  // R3: digit count never underflows and reaches zero at the final stage
  assert_digits_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (left_q != '0));
  assert_fin_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |-> (left_q == '0));

  // R7: one subtraction suffices
  assert_pre_sub_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |-> (pre_sum < m2_w));

  // R6: completed result is reduced
  assert_result_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < m_q));

  // R8: single-cycle completion strobe while idle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a start during an operation leaves the latched operands alone
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(m_q) && $stable(y_q) && $stable(ny_q)));
endmodule

// File: tb/sim_csd_mont_mul.sv
module sim_csd_mont_mul;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] op_x = '0, op_y = '0, op_m = 16'd1;
  logic         busy, done;
  logic [N-1:0] result;

  csd_mont_mul #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_x(op_x), .op_y(op_y), .op_m(op_m),
    .busy(busy), .done(done), .result(result)
  );

  always #10 clk = ~clk;

  int     n_cmp = 0, n_bad = 0, cyc = 0;
  bit     md_busy = 0, md_done = 0;
  int     md_cnt = 0;
  longint md_res = 0, md_pend = 0;

  // Signed digits by repeated halving with remainder in {-1,0,1}
  function automatic int step_count(longint x);
    int d[N+1];
    longint v = x;
    int i = 0, s = 0;
    for (int p = 0; p <= N; p++) begin
      if (v % 2 == 1) begin
        d[p] = (v % 4 == 1) ? 1 : -1;
        v = v - d[p];
      end else d[p] = 0;
      v = v / 2;
    end
    while (i <= N) begin
      if (i + 1 <= N && d[i+1] == 0) i += 2;
      else i += 1;
      s++;
    end
    return s;
  endfunction

  function automatic longint mont_ref(longint x, longint y, longint m);
    longint r = (x * y) % m;
    for (int p = 0; p <= N; p++) begin
      if (r % 2 == 1) r = r + m;
      r = r / 2;
    end
    return r;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural timing model
  always @(posedge clk) begin
    if (!rst_n) begin
      md_busy = 0; md_done = 0; md_cnt = 0; md_res = 0;
    end else begin
      md_done = 0;
      if (md_busy) begin
        if (md_cnt == 1) begin
          md_busy = 0; md_done = 1; md_res = md_pend;
        end else md_cnt--;
      end else if (start) begin
        md_busy = 1;
        md_cnt  = step_count(longint'(op_x)) + 1;
        md_pend = mont_ref(longint'(op_x), longint'(op_y), longint'(op_m));
      end
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 busy", longint'(busy), longint'(md_busy));
      chk("R8 done", longint'(done), longint'(md_done));
      chk("R6 R8 result", longint'(result), md_res);
    end
  end

  task automatic run_op(longint x, longint y, longint m, string tag);
    int k = 0;
    @(negedge clk);
    op_x = N'(x); op_y = N'(y); op_m = N'(m); start = 1'b1;
    do begin
      @(negedge clk);
      start = 1'b0;
      k++;
    end while (!done);
    chk(tag, longint'(result), mont_ref(x, y, m));
    chk("R3 latency", k, step_count(x) + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 result", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(5, 7, 13, "R6 small");
    // R4: long runs of ones give -1 digits; alternating gives only +1
    run_op(16'h7FFF, 16'h1234, 16'hFFFB, "R4 run of ones");
    run_op(16'h5555, 16'hABCD, 16'hFFFB, "R4 R2 alternating");
    run_op(16'hB6DB, 16'h9999, 16'hFFF1, "R4 mixed digits");
    // R5: modulus congruent to 1 and 3 mod 4
    run_op(16'h0F0F, 16'h7777, 16'h8001, "R5 m mod4 1");
    run_op(16'h0F0F, 16'h7777, 16'h8003, "R5 m mod4 3");
    // R10: boundaries
    run_op(0, 0, 1, "R10 m one");
    run_op(0, 16'h1234, 16'hFFFF, "R10 x zero");
    run_op(2, 2, 3, "R10 m three");
    run_op(16'hFFFE, 16'hFFFE, 16'hFFFF, "R10 max operands R7");

    // R9: start kept high with other operands while busy
    @(negedge clk);
    op_x = 16'h3C3C; op_y = 16'h0101; op_m = 16'hC001; start = 1'b1;
    @(negedge clk);
    op_x = 16'h1111; op_y = 16'h2222; op_m = 16'h4445;
    while (!done) @(negedge clk);
    start = 1'b0;
    chk("R9 start ignored", longint'(result), mont_ref(16'h3C3C, 16'h0101, 16'hC001));
    repeat (2) @(negedge clk);

    for (int t = 0; t < 60; t++) begin
      longint m, x, y;
      m = longint'($urandom() & 32'hFFFF) | 1;
      if (m < 3) m = 3;
      x = longint'($urandom()) % m;
      y = longint'($urandom()) % m;
      run_op(x, y, m, "R6 R7 random");
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule